// File: doc/BRIEF.md
# Banked Memory Self-Test Sequencer

This block tests a buffer memory that is split into banks and seen by the host through a single window the size of one bank. A pulse on `start` launches four full sweeps over the memory, always in the same order. The first sweep fills every word with an incrementing pattern. The second reads the pattern back and compares it. The third writes zero everywhere. The fourth reads every word back and expects zero. Each sweep takes the banks in ascending order. A bank is selected through a dedicated select strobe before any word inside it is written or read.

In the verify sweeps, the first word that does not match stops the test at once. The sequencer then freezes a report: a fail code that tells the pattern sweep from the zero sweep, the bank index, the word offset, the value read and the value expected. When all four sweeps finish with no mismatch, the test ends in the pass state. In both cases `done` rises and stays high until the next `start`. Parameters set the bank count, the words per bank, the data width, the read latency of the memory and the seed of the pattern.

Top module: `bank_mem_selftest`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `done`, `pass`, `fail_code`, `mem_we`, `mem_re` and `bank_sel_we` are all 0.
- R2: Before the first word access in a bank, in every sweep, the sequencer issues one `bank_sel_we` strobe with `bank_sel_en`=1 and `bank_sel_num` set to that bank. Banks are visited 0 up to NUM_BANKS-1, and the select takes effect from the next cycle.
- R3: In the fill sweep, word j of every bank is written with (SEED + j) modulo 2^DATA_W, for j rising from 0 to WORDS_PER_BANK-1.
- R4: In the pattern-verify sweep, every word of every bank is read in the same order and compared with SEED + j.
- R5: In the clear sweep, every word of every bank is written with 0.
- R6: In the zero-verify sweep, every word of every bank is read and must equal 0.
- R7: On the first mismatch, no further `mem_we`, `mem_re` or `bank_sel_we` strobe is issued. `fail_bank`, `fail_word`, `fail_read` and `fail_expect` hold the bank, the offset, the value read and the value expected.
- R8: `fail_code` is 0 after a clean run, 1 after a pattern-verify mismatch and 2 after a zero-verify mismatch. `pass` is 1 only with code 0 while `done` is high.
- R9: `done` and the report stay constant until the next `start`. A `start` pulse while a test is running is ignored. A `start` in the done state begins a new test, and `done` falls in the cycle after that start is sampled.
- R10: The read data for an access issued in cycle t is compared in cycle t+RD_LAT. A full clean run lasts exactly 2·B·(1+W) + 2·B·(1+W·(1+RD_LAT)) cycles, where B is the bank count and W is the number of words per bank.
- R11: In any one cycle at most one of `mem_we`, `mem_re` and `bank_sel_we` is high. A read is never issued in the cycle right after another read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a test when idle or done |
| done | output | 1 | Test finished; held until the next start |
| pass | output | 1 | Finished with no mismatch |
| fail_code | output | 2 | 0 none, 1 pattern mismatch, 2 zero mismatch |
| fail_bank | output | BANK_W | Bank of the first mismatch |
| fail_word | output | WORD_W | Word offset of the first mismatch |
| fail_read | output | DATA_W | Value read at the mismatch |
| fail_expect | output | DATA_W | Value expected at the mismatch |
| bank_sel_we | output | 1 | Bank select strobe |
| bank_sel_en | output | 1 | Enable bit sent with the select |
| bank_sel_num | output | BANK_W | Bank number to map into the window |
| mem_we | output | 1 | Window word write strobe |
| mem_re | output | 1 | Window word read strobe |
| mem_addr | output | WORD_W | Word offset inside the window |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after `mem_re` |

## Verification
The assertions watch a set of rules in every cycle. Strobes are mutually exclusive and reads are never back to back. Every select carries the enable bit and a legal bank number. No word is accessed before some bank has been selected. Offsets stay inside the window. Once `done` is high the memory port stays quiet and the report does not change. Some properties can only be shown by the bench scenarios, which run against a model memory. These are the exact pattern values including the 16-bit wrap of the seed, the bank-by-bank visiting order, the stop point and report contents for faults planted in either verify sweep, the total cycle count of a run, and the rule that a start pulse in mid-run is ignored.

// File: rtl/bms_pkg.sv
package bms_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_SEL, ST_ACC, ST_WAIT, ST_DONE
   } bms_state_e;

   // sweep order matters: fill, check pattern, clear, check zero
   typedef enum logic [1:0] {
      PH_FILL, PH_CHKPAT, PH_CLEAR, PH_CHKZERO
   } bms_phase_e;

   localparam logic [1:0] FC_NONE    = 2'd0;
   localparam logic [1:0] FC_PATTERN = 2'd1;
   localparam logic [1:0] FC_ZERO    = 2'd2;

   function automatic logic phase_reads(bms_phase_e p);
      return (p == PH_CHKPAT) || (p == PH_CHKZERO);
   endfunction

   function automatic logic phase_zero(bms_phase_e p);
      return (p == PH_CLEAR) || (p == PH_CHKZERO);
   endfunction
endpackage

// File: rtl/bms_walker.sv
// Bank / word position counter shared by all four sweeps.
module bms_walker #(
   parameter int NUM_BANKS      = 4,
   parameter int WORDS_PER_BANK = 4096,
   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int WORD_W = $clog2(WORDS_PER_BANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              step,
   output logic [BANK_W-1:0] bank,
   output logic [WORD_W-1:0] word,
   output logic              last_word,
   output logic              last_bank
);
   assign last_word = (word == WORD_W'(WORDS_PER_BANK - 1));
   assign last_bank = (bank == BANK_W'(NUM_BANKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank <= '0;
         word <= '0;
      end else if (restart) begin
         bank <= '0;
         word <= '0;
      end else if (step) begin
         if (last_word) begin
            word <= '0;
            bank <= last_bank ? '0 : bank + 1'b1;
         end else begin
            word <= word + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bms_judge.sv
// Expected-value generator, comparator and failure report capture.
module bms_judge #(
   parameter int              DATA_W = 16,
   parameter int              WORD_W = 12,
   parameter int              BANK_W = 2,
   parameter logic [DATA_W-1:0] SEED = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              zero_mode,
   input  logic              sample,
   input  logic [BANK_W-1:0] bank,
   input  logic [WORD_W-1:0] word,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] expect_val,
   output logic              mismatch,
   output logic [BANK_W-1:0] cap_bank,
   output logic [WORD_W-1:0] cap_word,
   output logic [DATA_W-1:0] cap_read,
   output logic [DATA_W-1:0] cap_expect
);
   assign expect_val = zero_mode ? '0 : DATA_W'(SEED + DATA_W'(word));
   assign mismatch   = sample && (rdata != expect_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_bank   <= '0;
         cap_word   <= '0;
         cap_read   <= '0;
         cap_expect <= '0;
      end else if (clear) begin
         cap_bank   <= '0;
         cap_word   <= '0;
         cap_read   <= '0;
         cap_expect <= '0;
      end else if (mismatch) begin
         cap_bank   <= bank;
         cap_word   <= word;
         cap_read   <= rdata;
         cap_expect <= expect_val;
      end
   end
endmodule

// File: rtl/bank_mem_selftest.sv
module bank_mem_selftest
   import bms_pkg::*;
#(
   parameter int              NUM_BANKS      = 4,
   parameter int              WORDS_PER_BANK = 4096,
   parameter int              DATA_W         = 16,
   parameter int              RD_LAT         = 1,
   parameter logic [DATA_W-1:0] SEED         = '0,
   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int WORD_W = $clog2(WORDS_PER_BANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              pass,
   output logic [1:0]        fail_code,
   output logic [BANK_W-1:0] fail_bank,
   output logic [WORD_W-1:0] fail_word,
   output logic [DATA_W-1:0] fail_read,
   output logic [DATA_W-1:0] fail_expect,
   output logic              bank_sel_we,
   output logic              bank_sel_en,
   output logic [BANK_W-1:0] bank_sel_num,
   output logic              mem_we,
   output logic              mem_re,
   output logic [WORD_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   generate
      if (NUM_BANKS < 1)       begin : g_bad_banks $error("NUM_BANKS must be >= 1"); end
      if (WORDS_PER_BANK < 2)  begin : g_bad_words $error("WORDS_PER_BANK must be >= 2"); end
      if (WORD_W > DATA_W)     begin : g_bad_width $error("word offset wider than data"); end
      if (RD_LAT < 1)          begin : g_bad_lat   $error("RD_LAT must be >= 1"); end
   endgenerate

   bms_state_e        state_q;
   bms_phase_e        phase_q;
   logic [1:0]        code_q;
   logic [BANK_W-1:0] bank;
   logic [WORD_W-1:0] word;
   logic              last_word, last_bank;
   logic              launch, step, sample, lat_last, lat_load, mismatch, rd_phase;
   logic [DATA_W-1:0] expect_val;

   assign rd_phase = phase_reads(phase_q);
   assign launch   = start && (state_q == ST_IDLE || state_q == ST_DONE);
   assign lat_load = (state_q == ST_ACC) && rd_phase;
   assign sample   = (state_q == ST_WAIT) && lat_last;
   assign step     = ((state_q == ST_ACC) && !rd_phase) || (sample && !mismatch);

   // read latency: a single wait cycle needs no counter
   generate
      if (RD_LAT == 1) begin : g_lat_one
         assign lat_last = 1'b1;
      end else begin : g_lat_multi
         localparam int LAT_W = $clog2(RD_LAT);
         logic [LAT_W-1:0] lat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       lat_q <= '0;
            else if (lat_load)                lat_q <= LAT_W'(RD_LAT - 1);
            else if (state_q == ST_WAIT && lat_q != '0) lat_q <= lat_q - 1'b1;
         end
         assign lat_last = (lat_q == '0);
      end
   endgenerate

   bms_walker #(.NUM_BANKS(NUM_BANKS), .WORDS_PER_BANK(WORDS_PER_BANK)) u_walk (
      .clk(clk), .rst_n(rst_n), .restart(launch), .step(step),
      .bank(bank), .word(word), .last_word(last_word), .last_bank(last_bank)
   );

   bms_judge #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BANK_W(BANK_W), .SEED(SEED)) u_judge (
      .clk(clk), .rst_n(rst_n), .clear(launch), .zero_mode(phase_zero(phase_q)),
      .sample(sample), .bank(bank), .word(word), .rdata(mem_rdata),
      .expect_val(expect_val), .mismatch(mismatch),
      .cap_bank(fail_bank), .cap_word(fail_word),
      .cap_read(fail_read), .cap_expect(fail_expect)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_FILL;
         code_q  <= FC_NONE;
      end else if (launch) begin
         state_q <= ST_SEL;
         phase_q <= PH_FILL;
         code_q  <= FC_NONE;
      end else begin
         case (state_q)
            ST_SEL:  state_q <= ST_ACC;
            ST_ACC:  if (rd_phase) state_q <= ST_WAIT;
            ST_WAIT: if (mismatch) begin
                        state_q <= ST_DONE;
                        code_q  <= (phase_q == PH_CHKPAT) ? FC_PATTERN : FC_ZERO;
                     end
            default: ;
         endcase
         if (step) begin
            if (!last_word) begin
               state_q <= ST_ACC;
            end else if (!last_bank) begin
               state_q <= ST_SEL;
            end else if (phase_q == PH_CHKZERO) begin
               state_q <= ST_DONE;
            end else begin
               phase_q <= bms_phase_e'(phase_q + 2'd1);
               state_q <= ST_SEL;
            end
         end
      end
   end

   assign done         = (state_q == ST_DONE);
   assign pass         = done && (code_q == FC_NONE);
   assign fail_code    = code_q;
   assign bank_sel_we  = (state_q == ST_SEL);
   assign bank_sel_en  = (state_q == ST_SEL);
   assign bank_sel_num = bank;
   assign mem_we       = (state_q == ST_ACC) && !rd_phase;
   assign mem_re       = lat_load;
   assign mem_addr     = word;
   assign mem_wdata    = expect_val;
endmodule

// File: rtl/bms_checker.sv
module bms_checker #(
   parameter int NUM_BANKS      = 4,
   parameter int WORDS_PER_BANK = 4096,
   parameter int DATA_W         = 16,
   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int WORD_W = $clog2(WORDS_PER_BANK)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input logic              pass,
   input logic [1:0]        fail_code,
   input logic [BANK_W-1:0] fail_bank,
   input logic [WORD_W-1:0] fail_word,
   input logic [DATA_W-1:0] fail_read,
   input logic              bank_sel_we,
   input logic              bank_sel_en,
   input logic [BANK_W-1:0] bank_sel_num,
   input logic              mem_we,
   input logic              mem_re,
   input logic [WORD_W-1:0] mem_addr
);
   logic sel_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sel_seen <= 1'b0;
      else if (bank_sel_we) sel_seen <= 1'b1;
   end

   p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mem_we, mem_re, bank_sel_we}) <= 1);

   p_read_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !mem_re);

   p_sel_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bank_sel_we |-> (bank_sel_en && bank_sel_num <= BANK_W'(NUM_BANKS - 1)));

   p_sel_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> sel_seen);

   p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> mem_addr <= WORD_W'(WORDS_PER_BANK - 1));

   p_quiet_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(mem_we || mem_re || bank_sel_we));

   p_hold_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(fail_code) && $stable(fail_bank)
                            && $stable(fail_word) && $stable(fail_read)));

   p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fail_code != 2'd3 && (pass == (fail_code == 2'd0))));

   p_idle_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !pass);
endmodule

bind bank_mem_selftest bms_checker #(
   .NUM_BANKS(NUM_BANKS), .WORDS_PER_BANK(WORDS_PER_BANK), .DATA_W(DATA_W)
) u_bms_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
   .fail_code(fail_code), .fail_bank(fail_bank), .fail_word(fail_word),
   .fail_read(fail_read), .bank_sel_we(bank_sel_we), .bank_sel_en(bank_sel_en),
   .bank_sel_num(bank_sel_num), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr)
);

// File: tb/tb_bank_mem_selftest.sv
module tb_bank_mem_selftest;
   localparam int B   = 4;
   localparam int W   = 16;
   localparam int DW  = 16;
   localparam int LAT = 1;
   localparam logic [15:0] SEED = 16'hFFF8;   // forces wrap of SEED+j
   localparam int BW  = 2;
   localparam int WW  = 4;
   localparam int RUN_CYC = 2*B*(1+W) + 2*B*(1+W*(1+LAT));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic done, pass, bank_sel_we, bank_sel_en, mem_we, mem_re;
   logic [1:0] fail_code;
   logic [BW-1:0] fail_bank, bank_sel_num;
   logic [WW-1:0] fail_word, mem_addr;
   logic [DW-1:0] fail_read, fail_expect, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   always #4 clk = ~clk;   // 125 MHz

   bank_mem_selftest #(.NUM_BANKS(B), .WORDS_PER_BANK(W), .DATA_W(DW),
                       .RD_LAT(LAT), .SEED(SEED)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
      .fail_code(fail_code), .fail_bank(fail_bank), .fail_word(fail_word),
      .fail_read(fail_read), .fail_expect(fail_expect),
      .bank_sel_we(bank_sel_we), .bank_sel_en(bank_sel_en), .bank_sel_num(bank_sel_num),
      .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // model memory with fault knobs: 1 = flip read bits, 2 = drop zero writes
   logic [DW-1:0] mem [0:B*W-1];
   int cur_bank = 0;
   int fault_mode = 0, fault_idx = 0;
   logic [DW-1:0] fault_mask = '0;
   logic clr = 1'b0;
   int n_wr = 0, n_rd = 0, n_sel = 0, ord_err = 0, clash = 0;

   always @(posedge clk) begin
      int idx;
      idx = cur_bank*W + int'(mem_addr);
      if (clr) begin
         n_wr <= 0; n_rd <= 0; n_sel <= 0; ord_err <= 0; clash <= 0;
      end else begin
         if (int'(mem_we) + int'(mem_re) + int'(bank_sel_we) > 1) clash <= clash + 1;
         if (bank_sel_we) begin
            n_sel <= n_sel + 1;
            if (!bank_sel_en || int'(bank_sel_num) != (n_sel % B)) ord_err <= ord_err + 1;
            if (bank_sel_en) cur_bank <= int'(bank_sel_num);
         end
         if (mem_we) begin
            n_wr <= n_wr + 1;
            if (cur_bank != (n_wr / W) % B || int'(mem_addr) != n_wr % W ||
                mem_wdata != ((n_wr < B*W) ? DW'(SEED + DW'(n_wr % W)) : '0))
               ord_err <= ord_err + 1;
            if (!(fault_mode == 2 && idx == fault_idx && mem_wdata == '0))
               mem[idx] <= mem_wdata;
         end
         if (mem_re) begin
            n_rd <= n_rd + 1;
            if (cur_bank != (n_rd / W) % B || int'(mem_addr) != n_rd % W)
               ord_err <= ord_err + 1;
            mem_rdata <= mem[idx] ^ ((fault_mode == 1 && idx == fault_idx) ? fault_mask : '0);
         end
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic clear_counts();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic launch(input int poke_at, output int cyc);
      clear_counts();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cyc = 0;
      while (!done && cyc < 5000) begin
         start = (cyc == poke_at);
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      if (!done) chk("R9 done never rose", 0, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 done in reset", done, 0);
      chk("R1 strobes in reset", {mem_we, mem_re, bank_sel_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done after reset", done, 0);
      chk("R1 pass after reset", pass, 0);
      chk("R1 code after reset", fail_code, 0);
      chk("R1 strobes after reset", {mem_we, mem_re, bank_sel_we}, 0);
   endtask

   task automatic t_clean();
      int cyc;
      bit all_zero;
      fault_mode = 0;
      launch(-1, cyc);
      chk("R8 pass flag clean", pass, 1);
      chk("R8 code clean", fail_code, 0);
      chk("R10 run length", cyc, RUN_CYC);
      chk("R3 R5 write count", n_wr, 2*B*W);
      chk("R4 R6 read count", n_rd, 2*B*W);
      chk("R2 select count", n_sel, 4*B);
      chk("R2 R3 R4 R5 R6 order and data", ord_err, 0);
      chk("R11 strobe clash", clash, 0);
      all_zero = 1'b1;
      for (int i = 0; i < B*W; i++) if (mem[i] != '0) all_zero = 1'b0;
      chk("R5 memory cleared", all_zero, 1);
   endtask

   task automatic t_pattern_fault();
      int cyc;
      fault_mode = 1; fault_idx = 2*W + 5; fault_mask = 16'h0100;
      launch(-1, cyc);
      chk("R8 code pattern", fail_code, 1);
      chk("R8 pass low", pass, 0);
      chk("R7 bank", fail_bank, 2);
      chk("R7 word", fail_word, 5);
      chk("R7 read", fail_read, 16'hFEFD);
      chk("R4 expect", fail_expect, 16'hFFFD);
      repeat (10) @(negedge clk);
      chk("R7 reads stop", n_rd, 2*W + 6);
      chk("R7 writes stop", n_wr, B*W);
      chk("R7 selects stop", n_sel, B + 3);
      fault_mode = 0;
   endtask

   task automatic t_zero_fault();
      int cyc;
      fault_mode = 2; fault_idx = 3*W + (W-1);
      launch(-1, cyc);
      chk("R8 code zero", fail_code, 2);
      chk("R6 bank", fail_bank, 3);
      chk("R6 word", fail_word, W-1);
      chk("R6 read", fail_read, 16'h0007);
      chk("R6 expect", fail_expect, 0);
      chk("R10 run length to last word", cyc, RUN_CYC);
      fault_mode = 0;
   endtask

   task automatic t_busy_start();
      int cyc;
      launch(50, cyc);
      chk("R9 start while busy ignored", cyc, RUN_CYC);
      chk("R9 pass after poke", pass, 1);
      repeat (12) @(negedge clk);
      chk("R9 done held", done, 1);
      chk("R9 code held", fail_code, 0);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R9 done drops on restart", done, 0);
      chk("R2 first cycle is select", bank_sel_we, 1);
      while (!done) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_clean();
      t_pattern_fault();
      t_zero_fault();
      t_busy_start();
      t_clean();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule